// File: doc/BRIEF.md
# Card Clock Divider with DDR Bypass Rules

This block derives the memory-card bus clock from the kernel clock. A non-zero divider code N makes a square wave with a period of 2·N kernel cycles and an equal high and low time. Code 0 passes the kernel clock straight through. Double-data-rate operation cannot use this bypass, so in that mode code 0 is treated as code 1. A new code takes effect only at the start of a low phase, so a change in rate never produces a shortened pulse. In double-data-rate mode the block also gives a one-cycle enable that marks each falling edge, for the sampler of the second data beat.

A timing-mode input is decoded, with one kernel cycle of latency, into the double-data-rate flag, the high-speed bus flag, the sampling-clock source and the lane-width field. A separate combinational helper turns a requested card rate in kHz into the divider code that software would program. It rounds the division up, it saturates at the largest code, and it maps a request of zero to the largest code so that the clock never stops.

Top module: `card_clk_div`

## Requirements
- R1: With a non-zero effective code N and the bypass path off, the card clock is high for N kernel cycles and then low for N kernel cycles, repeating.
- R2: Code 0 outside double-data-rate mode makes the card clock follow the kernel clock: high in each high half and low in each low half. Leaving bypass for a code N brings back the N/N pattern.
- R3: In double-data-rate mode, code 0 gives the same output as code 1, which is one cycle high and one cycle low.
- R4: Reset forces the card clock low and clears ddr_o, bus_speed_o, samp_sel_o and width_o to 0. The active code resets to the maximum value 2^CODE_W−1, so the first low phase and the first high phase after reset each last that many cycles.
- R5: A code change is applied only where a high phase ends. A high phase already under way finishes at the old length. A low phase already under way finishes at the old length and is followed by one full high phase at the old length.
- R6: ddr_neg_en_o is high for exactly the first kernel cycle of each card-clock low phase while double-data-rate mode is active, and it is low at all other times.
- R7: The timing-mode input uses this encoding: 0 basic, 1 embedded high speed, 2 card high speed, 3 UHS 12.5 MHz, 4 UHS 25 MHz, 5 UHS 50 MHz, 6 UHS 104 MHz, 7 card DDR, 8 embedded DDR, 9 embedded 200 MHz, 10 embedded 400 MHz, and 11 to 15 reserved. ddr_o is 1 only for codes 7 and 8. It is registered, so it shows the mode one kernel cycle after that mode was applied.
- R8: bus_speed_o is 1 for mode codes 5 to 10 and 0 otherwise. It is registered like ddr_o.
- R9: samp_sel_o is 2 (feedback clock) for mode code 6. For every other mode it equals src_sel_i, where 0 is the internal clock and 1 is the returned pad clock. It is registered like ddr_o.
- R10: width_o is 0 for lanes_i = 1, 1 for lanes_i = 4 and 2 for lanes_i = 8. Any other lane count gives 0. It is registered like ddr_o.
- R11: rate_code_o is computed combinationally from rate_req_i (in kHz) and the current mode. A request of 0 gives the maximum code. A request at or above IN_KHZ outside double-data-rate mode gives 0. Every other request gives ceil(IN_KHZ / (2·rate)), limited to the maximum code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Kernel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_code_i | input | CODE_W | Requested divider code, where 0 selects bypass |
| timing_i | input | 4 | Bus timing mode, encoded as in R7 |
| src_sel_i | input | 2 | Requested sampling-clock source |
| lanes_i | input | 4 | Data lane count (1, 4 or 8) |
| rate_req_i | input | RATE_W | Desired card rate in kHz, for the helper |
| card_ck_o | output | 1 | Card clock |
| ddr_neg_en_o | output | 1 | Falling-edge sample enable in double-data-rate mode |
| ddr_o | output | 1 | Double-data-rate mode flag |
| bus_speed_o | output | 1 | High-speed bus flag |
| samp_sel_o | output | 2 | Effective sampling-clock source |
| width_o | output | 2 | Lane-width field |
| rate_code_o | output | CODE_W | Divider code computed from rate_req_i |

## Verification
A corrupted active code or half-phase counter changes the high or low run length that is visible at card_ck_o. It shows within one card-clock period, that is 2·N kernel cycles. A load point in the wrong place shows as a mixed-length phase in the cycles right after a code change, which is why the bench changes the code both during a high phase and during a low phase. A fault in the bypass gate shows at the next kernel half-cycle, and a wrong strobe shows on the first falling edge of the card clock. The mode decode and the rate helper are swept over their whole input ranges, so any wrong entry appears within one cycle.

// File: rtl/card_clk_div_pkg.sv
package card_clk_div_pkg;

   typedef logic [3:0] tmode_t;

   // Mode order matters: the high-speed flag is a range compare.
   localparam tmode_t TM_BASE    = 4'd0;
   localparam tmode_t TM_HS_EMB  = 4'd1;
   localparam tmode_t TM_HS_CARD = 4'd2;
   localparam tmode_t TM_U12     = 4'd3;
   localparam tmode_t TM_U25     = 4'd4;
   localparam tmode_t TM_U50     = 4'd5;
   localparam tmode_t TM_U104    = 4'd6;
   localparam tmode_t TM_UDDR    = 4'd7;
   localparam tmode_t TM_EDDR    = 4'd8;
   localparam tmode_t TM_E200    = 4'd9;
   localparam tmode_t TM_E400    = 4'd10;

   localparam logic [1:0] SEL_CORE = 2'd0;
   localparam logic [1:0] SEL_RET  = 2'd1;
   localparam logic [1:0] SEL_FB   = 2'd2;

   function automatic logic tm_is_ddr(input tmode_t t);
      return (t == TM_UDDR) || (t == TM_EDDR);
   endfunction

   function automatic logic tm_is_fast(input tmode_t t);
      return (t >= TM_U50) && (t <= TM_E400);
   endfunction

   function automatic logic [1:0] lanes_field(input logic [3:0] n);
      case (n)
         4'd4:    return 2'd1;
         4'd8:    return 2'd2;
         default: return 2'd0;
      endcase
   endfunction

endpackage

// File: rtl/card_clk_div_mode.sv
module card_clk_div_mode
   import card_clk_div_pkg::*;
(
   input  logic       clk_i,
   input  logic       rst_ni,
   input  tmode_t     timing_i,
   input  logic [1:0] src_sel_i,
   input  logic [3:0] lanes_i,
   output logic       ddr_now_o,
   output logic       ddr_o,
   output logic       fast_o,
   output logic [1:0] samp_o,
   output logic [1:0] width_o
);

   assign ddr_now_o = tm_is_ddr(timing_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ddr_o   <= 1'b0;
         fast_o  <= 1'b0;
         samp_o  <= SEL_CORE;
         width_o <= 2'd0;
      end else begin
         ddr_o   <= tm_is_ddr(timing_i);
         fast_o  <= tm_is_fast(timing_i);
         samp_o  <= (timing_i == TM_U104) ? SEL_FB : src_sel_i;
         width_o <= lanes_field(lanes_i);
      end
   end

endmodule

// File: rtl/card_clk_div_gen.sv
module card_clk_div_gen #(
   parameter int CODE_W    = 10,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CODE_W-1:0] code_i,
   input  logic              ddr_i,
   output logic [CODE_W-1:0] code_act_o,
   output logic [CODE_W-1:0] cnt_o,
   output logic              div_q_o,
   output logic              byp_q_o,
   output logic              fall_stb_o
);

   localparam logic [CODE_W-1:0] CODE_MAX = '1;
   localparam logic [CODE_W-1:0] CODE_ONE = CODE_W'(1);

   logic [CODE_W-1:0] code_eff;
   logic              phase_end;

   generate
      if (BYPASS_EN) begin : g_byp
         assign code_eff = (ddr_i && code_i == '0) ? CODE_ONE : code_i;

         // Gate enable moves only while the kernel clock is low.
         always_ff @(negedge clk_i or negedge rst_ni) begin
            if (!rst_ni) byp_q_o <= 1'b0;
            else         byp_q_o <= (code_act_o == '0);
         end
      end else begin : g_nobyp
         assign code_eff = (code_i == '0) ? CODE_ONE : code_i;
         assign byp_q_o  = 1'b0;
      end
   endgenerate

   assign phase_end = (code_act_o != '0) && (cnt_o == code_act_o - CODE_ONE);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         code_act_o <= CODE_MAX;
         cnt_o      <= '0;
         div_q_o    <= 1'b0;
         fall_stb_o <= 1'b0;
      end else begin
         fall_stb_o <= 1'b0;
         if (code_act_o == '0) begin
            code_act_o <= code_eff;
            cnt_o      <= '0;
            div_q_o    <= 1'b0;
         end else if (phase_end) begin
            cnt_o <= '0;
            if (div_q_o) begin
               div_q_o    <= 1'b0;
               code_act_o <= code_eff;
               fall_stb_o <= ddr_i;
            end else begin
               div_q_o <= 1'b1;
            end
         end else begin
            cnt_o <= cnt_o + CODE_ONE;
         end
      end
   end

endmodule

// File: rtl/card_clk_div_rate.sv
module card_clk_div_rate #(
   parameter int CODE_W    = 10,
   parameter int RATE_W    = 20,
   parameter int IN_KHZ    = 200000,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic [RATE_W-1:0] rate_i,
   input  logic              ddr_i,
   output logic [CODE_W-1:0] code_o
);

   localparam int NUM_W = RATE_W + 2;
   localparam int MAXV  = (1 << CODE_W) - 1;
   localparam logic [NUM_W-1:0]  IN_N   = NUM_W'(IN_KHZ);
   localparam logic [RATE_W-1:0] IN_R   = RATE_W'(IN_KHZ);
   localparam logic [NUM_W-1:0]  MAX_N  = NUM_W'(MAXV);

   logic [NUM_W-1:0] den;
   logic [NUM_W-1:0] num;
   logic [NUM_W-1:0] quo;

   assign den = (rate_i == '0) ? NUM_W'(1) : {1'b0, rate_i, 1'b0};
   assign num = IN_N + den - NUM_W'(1);
   assign quo = num / den;

   always_comb begin
      if (rate_i == '0)
         code_o = '1;
      else if (BYPASS_EN && !ddr_i && rate_i >= IN_R)
         code_o = '0;
      else if (quo > MAX_N)
         code_o = '1;
      else
         code_o = quo[CODE_W-1:0];
   end

endmodule

// File: rtl/card_clk_div.sv
module card_clk_div
   import card_clk_div_pkg::*;
#(
   parameter int CODE_W    = 10,
   parameter int RATE_W    = 20,
   parameter int IN_KHZ    = 200000,
   parameter bit BYPASS_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [CODE_W-1:0] div_code_i,
   input  logic [3:0]        timing_i,
   input  logic [1:0]        src_sel_i,
   input  logic [3:0]        lanes_i,
   input  logic [RATE_W-1:0] rate_req_i,
   output logic              card_ck_o,
   output logic              ddr_neg_en_o,
   output logic              ddr_o,
   output logic              bus_speed_o,
   output logic [1:0]        samp_sel_o,
   output logic [1:0]        width_o,
   output logic [CODE_W-1:0] rate_code_o
);

   generate
      if (CODE_W < 2 || CODE_W > 16) begin : g_bad_code_w
         $error("card_clk_div: CODE_W must be 2..16");
      end
      if (RATE_W < 2 || RATE_W > 30) begin : g_bad_rate_w
         $error("card_clk_div: RATE_W must be 2..30");
      end
      if (IN_KHZ < 1 || IN_KHZ >= (1 << RATE_W)) begin : g_bad_in_khz
         $error("card_clk_div: IN_KHZ must fit in RATE_W bits");
      end
   endgenerate

   logic              ddr_now;
   logic [CODE_W-1:0] code_act;
   logic [CODE_W-1:0] cnt;
   logic              div_q;
   logic              byp_q;

   card_clk_div_mode u_mode (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .timing_i  (timing_i),
      .src_sel_i (src_sel_i),
      .lanes_i   (lanes_i),
      .ddr_now_o (ddr_now),
      .ddr_o     (ddr_o),
      .fast_o    (bus_speed_o),
      .samp_o    (samp_sel_o),
      .width_o   (width_o)
   );

   card_clk_div_gen #(
      .CODE_W    (CODE_W),
      .BYPASS_EN (BYPASS_EN)
   ) u_gen (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .code_i     (div_code_i),
      .ddr_i      (ddr_o),
      .code_act_o (code_act),
      .cnt_o      (cnt),
      .div_q_o    (div_q),
      .byp_q_o    (byp_q),
      .fall_stb_o (ddr_neg_en_o)
   );

   card_clk_div_rate #(
      .CODE_W    (CODE_W),
      .RATE_W    (RATE_W),
      .IN_KHZ    (IN_KHZ),
      .BYPASS_EN (BYPASS_EN)
   ) u_rate (
      .rate_i (rate_req_i),
      .ddr_i  (ddr_now),
      .code_o (rate_code_o)
   );

   // Divided phase, or the kernel clock gated by a low-phase enable.
   assign card_ck_o = div_q | (clk_i & byp_q);

endmodule

// File: rtl/card_clk_div_chk.sv
module card_clk_div_chk
   import card_clk_div_pkg::*;
#(
   parameter int CODE_W = 10
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic [3:0]        timing_i,
   input logic              ddr_o,
   input logic              bus_speed_o,
   input logic [1:0]        samp_sel_o,
   input logic              ddr_neg_en_o,
   input logic [CODE_W-1:0] code_act,
   input logic [CODE_W-1:0] cnt,
   input logic              div_q,
   input logic              byp_q
);

   logic seen;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) seen <= 1'b0;
      else         seen <= 1'b1;
   end

   assert_cnt_bound_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code_act != '0) |-> (cnt < code_act));

   assert_byp_low_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      byp_q |-> !div_q);

   assert_ddr_no_byp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ddr_o && code_act == '0) |=> (code_act != '0));

   assert_load_in_low_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(code_act) |-> !div_q);

   assert_stb_on_fall_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ddr_neg_en_o |-> (!div_q && $past(div_q) && $past(ddr_o)));

   assert_ddr_decode_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      seen |-> (ddr_o == tm_is_ddr($past(timing_i))));

   assert_fb_select_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seen && $past(timing_i) == TM_U104) |-> (samp_sel_o == SEL_FB && bus_speed_o));

endmodule

bind card_clk_div card_clk_div_chk #(.CODE_W(CODE_W)) u_chk (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .timing_i     (timing_i),
   .ddr_o        (ddr_o),
   .bus_speed_o  (bus_speed_o),
   .samp_sel_o   (samp_sel_o),
   .ddr_neg_en_o (ddr_neg_en_o),
   .code_act     (code_act),
   .cnt          (cnt),
   .div_q        (div_q),
   .byp_q        (byp_q)
);

// File: tb/card_clk_div_bench.sv
`timescale 1ns/1ps
module card_clk_div_bench;

   localparam int CW   = 4;
   localparam int RW   = 20;
   localparam int INK  = 200000;
   localparam int MAXC = 15;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [CW-1:0] code = CW'(5);
   logic [3:0]    tm = 4'd0;
   logic [1:0]    src = 2'd0;
   logic [3:0]    lanes = 4'd1;
   logic [RW-1:0] rate = '0;

   logic          ck;
   logic          dneg;
   logic          ddr;
   logic          speed;
   logic [1:0]    samp;
   logic [1:0]    width;
   logic [CW-1:0] rcode;

   card_clk_div #(.CODE_W(CW), .RATE_W(RW), .IN_KHZ(INK), .BYPASS_EN(1'b1)) u_card_clk_div (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .div_code_i   (code),
      .timing_i     (tm),
      .src_sel_i    (src),
      .lanes_i      (lanes),
      .rate_req_i   (rate),
      .card_ck_o    (ck),
      .ddr_neg_en_o (dneg),
      .ddr_o        (ddr),
      .bus_speed_o  (speed),
      .samp_sel_o   (samp),
      .width_o      (width),
      .rate_code_o  (rcode)
   );

   always #2 clk = ~clk;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic wait_edge(input bit rising, output bit ok);
      bit prev;
      prev = ck;
      ok = 1'b0;
      for (int i = 0; i < 200; i++) begin
         step();
         if (rising ? (!prev && ck) : (prev && !ck)) begin
            ok = 1'b1;
            break;
         end
         prev = ck;
      end
   endtask

   task automatic count_run(input bit v, output int n);
      n = 0;
      for (int i = 0; i < 100; i++) begin
         if (ck != v) break;
         n++;
         step();
      end
   endtask

   function automatic int exp_code(input int w, input bit dd);
      int q;
      if (w == 0) return MAXC;
      if (w >= INK && !dd) return 0;
      q = (INK + 2 * w - 1) / (2 * w);
      return (q > MAXC) ? MAXC : q;
   endfunction

   initial begin
      repeat (120000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      bit ok;
      int h, l, e, bad;
      bit prev;

      // R4: reset state
      step();
      chk(ck == 1'b0 && ddr == 1'b0 && speed == 1'b0 && samp == 2'd0 && width == 2'd0,
          "R4 reset outputs", {ck, ddr, speed, samp, width}, 0);
      step();
      rst_n = 1'b1;
      count_run(1'b0, l);
      chk(l == MAXC, "R4 first low run", l, MAXC);
      count_run(1'b1, h);
      chk(h == MAXC, "R4 first high run", h, MAXC);

      // R1 / R3 / R6: sweep every code, plain and double data rate
      for (int d = 0; d < 2; d++) begin
         for (int c = 0; c <= MAXC; c++) begin
            if (c == 0 && d == 0) continue;
            tm = d ? 4'd7 : 4'd0;
            code = CW'(c);
            repeat (70) step();
            e = (c == 0) ? 1 : c;
            wait_edge(1'b1, ok);
            count_run(1'b1, h);
            count_run(1'b0, l);
            chk(ok && h == e && l == e,
                $sformatf("%s run code=%0d ddr=%0d high/low", (c == 0) ? "R3" : "R1", c, d),
                h * 100 + l, e * 100 + e);
            bad = 0;
            prev = ck;
            for (int i = 0; i < 4 * e + 4; i++) begin
               step();
               if (dneg != ((prev && !ck) && (d == 1))) bad++;
               prev = ck;
            end
            chk(bad == 0, $sformatf("R6 strobe code=%0d ddr=%0d mismatches", c, d), bad, 0);
         end
      end

      // R2: bypass follows kernel clock
      tm = 4'd0;
      code = '0;
      repeat (70) step();
      bad = 0;
      for (int i = 0; i < 8; i++) begin
         @(posedge clk); #1;
         if (ck !== 1'b1) bad++;
         @(negedge clk); #1;
         if (ck !== 1'b0 || dneg !== 1'b0) bad++;
      end
      chk(bad == 0, "R2 bypass mismatches", bad, 0);
      code = CW'(2);
      repeat (10) step();
      wait_edge(1'b1, ok);
      count_run(1'b1, h);
      count_run(1'b0, l);
      chk(ok && h == 2 && l == 2, "R2 leave bypass high/low", h * 100 + l, 202);

      // R5: change during a high phase
      code = CW'(6);
      repeat (40) step();
      wait_edge(1'b1, ok);
      step();
      step();
      code = CW'(3);
      count_run(1'b1, h);
      chk(ok && h == 4, "R5 high phase keeps old length", h, 4);
      count_run(1'b0, l);
      chk(l == 3, "R5 next low uses new code", l, 3);
      count_run(1'b1, h);
      chk(h == 3, "R5 next high uses new code", h, 3);

      // R5: change during a low phase
      code = CW'(6);
      repeat (40) step();
      wait_edge(1'b0, ok);
      step();
      step();
      code = CW'(3);
      count_run(1'b0, l);
      chk(ok && l == 4, "R5 low phase keeps old length", l, 4);
      count_run(1'b1, h);
      chk(h == 6, "R5 following high keeps old length", h, 6);
      count_run(1'b0, l);
      chk(l == 3, "R5 later low uses new code", l, 3);
      count_run(1'b1, h);
      chk(h == 3, "R5 later high uses new code", h, 3);

      // R7..R10: mode decode sweep
      for (int t = 0; t < 16; t++) begin
         int lv;
         int ew;
         lv = (t % 4 == 0) ? 1 : (t % 4 == 1) ? 4 : (t % 4 == 2) ? 8 : 2;
         ew = (lv == 4) ? 1 : (lv == 8) ? 2 : 0;
         tm = 4'(t);
         src = 2'(t % 3);
         lanes = 4'(lv);
         step();
         chk(ddr == ((t == 7) || (t == 8)), $sformatf("R7 ddr mode=%0d", t), ddr, (t == 7) || (t == 8));
         chk(speed == ((t >= 5) && (t <= 10)), $sformatf("R8 speed mode=%0d", t), speed, (t >= 5) && (t <= 10));
         chk(samp == ((t == 6) ? 2'd2 : 2'(t % 3)), $sformatf("R9 select mode=%0d", t), samp, (t == 6) ? 2 : t % 3);
         chk(width == 2'(ew), $sformatf("R10 width lanes=%0d", lv), width, ew);
      end

      // R11: rate helper
      for (int d = 0; d < 2; d++) begin
         int rl [10];
         rl = '{0, 1000, 7000, 8000, 13334, 99999, 100000, 150000, 200000, 300000};
         tm = d ? 4'd8 : 4'd0;
         for (int k = 0; k < 10; k++) begin
            rate = RW'(rl[k]);
            #1;
            e = exp_code(rl[k], d == 1);
            chk(rcode == CW'(e), $sformatf("R11 rate=%0d ddr=%0d", rl[k], d), rcode, e);
         end
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule